// File: doc/BRIEF.md
# Sorted Table Shift-Insert Engine

This block holds a table of key/data entries in ascending key order. The smallest key is at address 0, and valid entries fill addresses 0 up to count-1. Each command is one of two kinds. An insert opens a slot by moving every entry with a larger key down one place and then writes the new entry into the slot. A delete closes the gap left by the removed entry by moving every later entry up one place. The cost of an update therefore grows with the number of entries between its position and the end of the table.

Table moves are only allowed in update slots. An internal scheduler splits time into match periods. The first RESERVE cycles of each period belong to a searcher outside this block, which needs them to run a search and hold its result. Only the cycles after that are update slots, and each update slot moves exactly one entry. A search may be launched only in the first cycle of a period. The searcher reads entries through a combinational read port. While an update is in progress the engine reports busy and accepts no new commands.

Top module: `stse_top`

## Requirements
- R1: After reset, count is 0, busy and done are low, and the first cycle after reset is cycle 0 of a match period.
- R2: The effective period is P cycles. Cycle positions 0..RESERVE-1 of each period are the match window and positions RESERVE..P-1 are update slots, where upd_slot is high. search_go equals search_req in position 0 and is low in every other position.
- R3: For every address below count, the read port gives rd_valid high and the stored key and data. Keys rise strictly with address. Addresses at or above count give rd_valid low.
- R4: Let pos be the number of stored keys smaller than the new key. An insert of an absent key into a non-full table keeps busy high for exactly count-pos+1 update slots. It then pulses done with status 0 (ok) and count rises by one.
- R5: A delete of a present key at address pos keeps busy high for exactly count-pos update slots. It then pulses done with status 0 and count falls by one.
- R6: An insert of a key already present overwrites that entry's data in place. This holds even when the table is full. done pulses in the cycle after acceptance with status 1 (replaced), busy stays low and count is unchanged.
- R7: A delete of an absent key pulses done in the cycle after acceptance with status 2 (not found) and leaves the table unchanged.
- R8: An insert of a new key into a table holding DEPTH entries pulses done in the cycle after acceptance with status 3 (overflow) and leaves the table unchanged. count never exceeds DEPTH.
- R9: A command is accepted only while busy is low. A command presented while busy is high has no effect on the table.
- R10: The effective period P is period_len when period_len is at least RESERVE+1, and RESERVE+1 otherwise.
- R11: cmd_op 0 selects insert and 1 selects delete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_len | input | PER_W | Requested match period in cycles |
| search_req | input | 1 | Searcher wants to start a search |
| search_go | output | 1 | Search may start in this cycle |
| upd_slot | output | 1 | Current cycle is an update slot |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 insert, 1 delete |
| cmd_key | input | KEY_W | Command key |
| cmd_data | input | DATA_W | Data for insert |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result of the last command |
| count | output | CNT_W | Number of valid entries |
| rd_addr | input | IDX_W | Read address |
| rd_valid | output | 1 | Read address holds a valid entry |
| rd_key | output | KEY_W | Key at read address |
| rd_data | output | DATA_W | Data at read address |

## Verification
The bench exercises inserts at the top, in the middle and at the bottom of the table, because the update time depends on position. An off-by-one in the shift loop would make busy end one slot early or late, or would duplicate or drop the neighbouring entry. It inserts a duplicate key into a full table, where an engine that checks for overflow before checking for equal keys would wrongly report overflow. It pulses a delete while an insert is shifting, which an engine without the busy interlock would corrupt. It also changes the period, including to a value below the reserved window, which a scheduler without the lower clamp would turn into a period with no update slots.

// File: rtl/stse_pkg.sv
package stse_pkg;

    localparam int KEY_W  = 12;
    localparam int DATA_W = 16;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [DATA_W-1:0] dat_t;

    typedef struct packed {
        key_t key;
        dat_t data;
    } entry_t;

    typedef enum logic {
        OP_INSERT = 1'b0,
        OP_DELETE = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_REPLACED  = 2'd1,
        ST_NOT_FOUND = 2'd2,
        ST_OVERFLOW  = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_CLOSE = 2'd2
    } phase_e;

    // Effective period: never shorter than the reserved window plus one slot
    function automatic int unsigned clamp_period(input int unsigned req,
                                                 input int unsigned reserve);
        return (req < reserve + 1) ? reserve + 1 : req;
    endfunction

endpackage

// File: rtl/stse_sched.sv
module stse_sched #(
    parameter int PER_W   = 8,
    parameter int RESERVE = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_len,
    input  logic             search_req,
    output logic             search_go,
    output logic             upd_slot
);
    import stse_pkg::*;

    logic [PER_W-1:0] pcnt;
    logic [PER_W-1:0] eff;

    always_comb begin
        eff = PER_W'(clamp_period(int'(period_len), RESERVE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (pcnt >= eff - 1'b1) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign upd_slot  = (pcnt >= PER_W'(RESERVE));
    assign search_go = search_req && (pcnt == '0);

endmodule

// File: rtl/stse_locate.sv
module stse_locate #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  stse_pkg::entry_t [DEPTH-1:0] ents,
    input  logic [CNT_W-1:0]             count,
    input  stse_pkg::key_t               key,
    output logic [CNT_W-1:0]             pos,
    output logic                         hit
);
    // pos = number of valid keys below 'key'; hit = key already stored
    always_comb begin
        pos = '0;
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < count) begin
                if (ents[i].key < key) pos = pos + 1'b1;
                if (ents[i].key == key) hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/stse_store.sv
module stse_store #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  stse_pkg::entry_t             wr_ent,
    output stse_pkg::entry_t [DEPTH-1:0] ents
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ents[g] <= wr_ent;
            end
        end
    end

endmodule

// File: rtl/stse_top.sv
module stse_top #(
    parameter int DEPTH   = 16,
    parameter int PER_W   = 8,
    parameter int RESERVE = 18,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PER_W-1:0]           period_len,
    input  logic                       search_req,
    output logic                       search_go,
    output logic                       upd_slot,
    input  logic                       cmd_valid,
    input  logic                       cmd_op,
    input  logic [stse_pkg::KEY_W-1:0]  cmd_key,
    input  logic [stse_pkg::DATA_W-1:0] cmd_data,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 status,
    output logic [CNT_W-1:0]           count,
    input  logic [IDX_W-1:0]           rd_addr,
    output logic                       rd_valid,
    output logic [stse_pkg::KEY_W-1:0]  rd_key,
    output logic [stse_pkg::DATA_W-1:0] rd_data
);
    import stse_pkg::*;

    entry_t [DEPTH-1:0] ents;
    phase_e             phase;
    logic [CNT_W-1:0]   cnt, ptr, tgt, pos;
    logic               hit, accept;
    entry_t             pend;
    status_e            stat_q;
    logic               done_q;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    entry_t             wr_ent;

    stse_sched #(.PER_W(PER_W), .RESERVE(RESERVE)) u_sched (
        .clk(clk), .rst(rst), .period_len(period_len),
        .search_req(search_req), .search_go(search_go), .upd_slot(upd_slot)
    );

    stse_locate #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_loc (
        .ents(ents), .count(cnt), .key(cmd_key), .pos(pos), .hit(hit)
    );

    stse_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .ents(ents)
    );

    assign accept = cmd_valid && (phase == PH_IDLE);

    // Single write port: in-place replace, one shift step, or final write/clear
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = '0;
        wr_ent = pend;
        unique case (phase)
            PH_IDLE: begin
                if (accept && op_e'(cmd_op) == OP_INSERT && hit) begin
                    wr_en  = 1'b1;
                    wr_idx = IDX_W'(pos);
                    wr_ent = '{key: cmd_key, data: cmd_data};
                end
            end
            PH_OPEN: begin
                if (upd_slot) begin
                    wr_en = 1'b1;
                    if (ptr > tgt) begin
                        wr_idx = IDX_W'(ptr);
                        wr_ent = ents[IDX_W'(ptr - 1'b1)];
                    end else begin
                        wr_idx = IDX_W'(tgt);
                        wr_ent = pend;
                    end
                end
            end
            PH_CLOSE: begin
                if (upd_slot) begin
                    wr_en  = 1'b1;
                    wr_idx = IDX_W'(ptr);
                    if (ptr + 1'b1 < cnt) begin
                        wr_ent = ents[IDX_W'(ptr + 1'b1)];
                    end else begin
                        wr_ent = '0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            ptr    <= '0;
            tgt    <= '0;
            pend   <= '0;
            stat_q <= ST_OK;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        if (op_e'(cmd_op) == OP_INSERT) begin
                            if (hit) begin
                                done_q <= 1'b1;
                                stat_q <= ST_REPLACED;
                            end else if (cnt == CNT_W'(DEPTH)) begin
                                done_q <= 1'b1;
                                stat_q <= ST_OVERFLOW;
                            end else begin
                                phase <= PH_OPEN;
                                ptr   <= cnt;
                                tgt   <= pos;
                                pend  <= '{key: cmd_key, data: cmd_data};
                            end
                        end else begin
                            if (!hit) begin
                                done_q <= 1'b1;
                                stat_q <= ST_NOT_FOUND;
                            end else begin
                                phase <= PH_CLOSE;
                                ptr   <= pos;
                            end
                        end
                    end
                end
                PH_OPEN: begin
                    if (upd_slot) begin
                        if (ptr > tgt) begin
                            ptr <= ptr - 1'b1;
                        end else begin
                            phase  <= PH_IDLE;
                            cnt    <= cnt + 1'b1;
                            done_q <= 1'b1;
                            stat_q <= ST_OK;
                        end
                    end
                end
                PH_CLOSE: begin
                    if (upd_slot) begin
                        if (ptr + 1'b1 < cnt) begin
                            ptr <= ptr + 1'b1;
                        end else begin
                            phase  <= PH_IDLE;
                            cnt    <= cnt - 1'b1;
                            done_q <= 1'b1;
                            stat_q <= ST_OK;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign done     = done_q;
    assign status   = stat_q;
    assign count    = cnt;
    assign rd_valid = ({1'b0, rd_addr} < (CNT_W + 1)'(cnt));
    assign rd_key   = ents[rd_addr].key;
    assign rd_data  = ents[rd_addr].data;

endmodule

// File: rtl/stse_chk.sv
module stse_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic [CNT_W-1:0] count,
    input logic             upd_slot,
    input logic             search_go
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8

    AST_SEARCH_NOT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        search_go |-> !upd_slot); // R2

    AST_COUNT_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        !(busy && upd_slot) |=> $stable(count)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> (count == $past(count) + 1'b1 || count + 1'b1 == $past(count))); // R5

    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && status == 2'd0)); // R4

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done); // R9

    AST_FAST_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && status != 2'd0) |-> !$past(busy)); // R7

endmodule

bind stse_top stse_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status),
    .count(count), .upd_slot(upd_slot), .search_go(search_go)
);

// File: tb/test_stse_top.sv
`timescale 1ns/1ps
module test_stse_top;
    import stse_pkg::*;

    localparam int DEPTH = 16;
    localparam int PER_W = 8;
    localparam int RES   = 18;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic [PER_W-1:0]  period_len = 8'd20;
    logic              search_req = 1'b0;
    logic              search_go, upd_slot;
    logic              cmd_valid = 1'b0;
    logic              cmd_op = 1'b0;
    logic [KEY_W-1:0]  cmd_key = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              busy, done, rd_valid;
    logic [1:0]        status;
    logic [CNT_W-1:0]  count;
    logic [IDX_W-1:0]  rd_addr = '0;
    logic [KEY_W-1:0]  rd_key;
    logic [DATA_W-1:0] rd_data;

    stse_top #(.DEPTH(DEPTH), .PER_W(PER_W), .RESERVE(RES)) i_stse_top (
        .clk(clk), .rst(rst), .period_len(period_len), .search_req(search_req),
        .search_go(search_go), .upd_slot(upd_slot), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_data(cmd_data), .busy(busy),
        .done(done), .status(status), .count(count), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_key(rd_key), .rd_data(rd_data)
    );

    typedef struct { int key; int data; } ment_t;
    ment_t mq[$];
    int m_pc = 0, m_busy = 0, m_rem = 0, m_done = 0, m_stat = 0, m_op = 0, m_pos = 0;
    ment_t m_pend;
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_p();
        return (int'(period_len) < RES + 1) ? RES + 1 : int'(period_len);
    endfunction

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_busy = 0; m_done = 0; m_stat = 0; mq.delete();
        end else begin
            bit slot;
            slot = (m_pc >= RES);
            m_done = 0;
            if (m_busy != 0) begin
                if (slot) begin
                    m_rem--;
                    if (m_rem == 0) begin
                        if (m_op == 0) mq.insert(m_pos, m_pend);
                        else mq.delete(m_pos);
                        m_busy = 0; m_done = 1; m_stat = 0;
                    end
                end
            end else if (cmd_valid) begin
                int p; bit h;
                p = 0; h = 0;
                foreach (mq[i]) begin
                    if (mq[i].key < int'(cmd_key)) p++;
                    if (mq[i].key == int'(cmd_key)) h = 1;
                end
                if (cmd_op == 1'b0) begin
                    if (h) begin
                        mq[p].data = int'(cmd_data); m_done = 1; m_stat = 1;
                    end else if (mq.size() == DEPTH) begin
                        m_done = 1; m_stat = 3;
                    end else begin
                        m_busy = 1; m_rem = mq.size() - p + 1; m_op = 0; m_pos = p;
                        m_pend.key = int'(cmd_key); m_pend.data = int'(cmd_data);
                    end
                end else begin
                    if (!h) begin
                        m_done = 1; m_stat = 2;
                    end else begin
                        m_busy = 1; m_rem = mq.size() - p; m_op = 1; m_pos = p;
                    end
                end
            end
            m_pc = (m_pc >= eff_p() - 1) ? 0 : m_pc + 1;
        end
    end

    // Per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy[0], "R4 busy", int'(busy), m_busy);
            chk(int'(count) == mq.size(), "R5 count", int'(count), mq.size());
            chk(done == m_done[0], "R6 done", int'(done), m_done);
            if (m_done != 0) chk(int'(status) == m_stat, "R7 status", int'(status), m_stat);
            chk(upd_slot == (m_pc >= RES), "R2 upd_slot", int'(upd_slot), int'(m_pc >= RES));
            chk(search_go == (search_req && m_pc == 0), "R2 search_go",
                int'(search_go), int'(search_req && m_pc == 0));
        end
    end

    task automatic run_cmd(input bit op, input int key, input int data,
                           input string req, input int exp_stat);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_key = KEY_W'(key); cmd_data = DATA_W'(data);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(int'(status) == exp_stat, req, int'(status), exp_stat);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); #1;
            rd_addr = IDX_W'(a);
            #1;
            if (a < mq.size()) begin
                chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
                chk(int'(rd_key) == mq[a].key, req, int'(rd_key), mq[a].key);
                chk(int'(rd_data) == mq[a].data, req, int'(rd_data), mq[a].data);
                if (a > 0) chk(mq[a].key > mq[a-1].key, req, mq[a].key, mq[a-1].key);
            end else begin
                chk(rd_valid == 1'b0, req, int'(rd_valid), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(count == '0, "R1 count", int'(count), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(upd_slot == 1'b0, "R1 period start", int'(upd_slot), 0);

        search_req = 1'b1;                         // R2 search gating
        run_cmd(0, 50, 16'h0500, "R4 insert empty", 0);   // R11 op 0
        run_cmd(0, 10, 16'h0100, "R4 insert top", 0);
        run_cmd(0, 90, 16'h0900, "R4 insert bottom", 0);
        run_cmd(0, 30, 16'h0300, "R4 insert middle", 0);
        run_cmd(0, 70, 16'h0700, "R4 insert middle", 0);
        search_req = 1'b0;
        sweep("R3 after inserts");

        run_cmd(0, 30, 16'h3333, "R6 replace", 1);
        run_cmd(1, 10, 0, "R5 delete top", 0);     // R11 op 1
        run_cmd(1, 90, 0, "R5 delete bottom", 0);
        run_cmd(1, 55, 0, "R7 delete absent", 2);
        sweep("R7 table kept");

        // R9: delete pulsed during an insert shift is ignored
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_key = 12'd20; cmd_data = 16'h0200;
        @(posedge clk); #1 cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        #1 cmd_valid = 1'b1; cmd_op = 1'b1; cmd_key = 12'd50;
        @(posedge clk); #1 cmd_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(int'(count) == 4, "R9 busy ignore", int'(count), 4);
        sweep("R9 key 50 kept");

        period_len = 8'd24;                        // R10 longer period
        run_cmd(0, 60, 16'h0600, "R10 period 24", 0);
        period_len = 8'd5;                         // R10 clamped
        run_cmd(0, 5, 16'h0050, "R10 clamped period", 0);
        period_len = 8'd20;

        for (int i = 0; i < 10; i++) run_cmd(0, 100 + i, 16'h1000 + i, "R4 fill", 0);
        chk(int'(count) == DEPTH, "R8 full", int'(count), DEPTH);
        run_cmd(0, 200, 16'hBEEF, "R8 overflow", 3);
        run_cmd(0, 100, 16'hCAFE, "R6 replace when full", 1);
        run_cmd(0, 1, 16'h0001, "R8 overflow top", 3);
        sweep("R8 table kept");
        run_cmd(1, 5, 0, "R5 delete top of full", 0);
        sweep("R3 final");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule